// File: doc/BRIEF.md
# D-PHY Lane Mode Sequencer

This block sits between a byte packetizer and the lane drivers of a serial display transmitter. It watches a single request, `hs_en_i`, which the packetizer raises while it has a packet to send. It then moves one clock lane and a set of data lanes out of the low-power idle state and into high-speed mode, and later brings them back. The block drives the low-power pin-pair state of every lane, the high-speed output enables, a lead byte for the data lanes, and a data-valid strobe that lets payload bytes into the serializer.

The clock lane always changes mode first on the way in and last on the way out. Four parameters, each counted in byte clocks, set how the mode changes are spaced. `CLK_LEAD_CYC` is how long the clock lane runs in high-speed mode before the data lanes begin to move. `DATA_LEAD_CYC` is how long the data lanes run in high-speed mode before payload starts. `DATA_TAIL_CYC` is how long the data lanes stay in high-speed mode after payload ends. `CLK_TAIL_CYC` is how long the clock lane keeps running after the data lanes have gone back to low power. Each of these must be at least 1.

A lane's pin-pair state is written `{p, n}`. LP11 is `2'b11`, LP01 is `2'b01` and LP00 is `2'b00`. Data lane k uses bits `[2k+1:2k]` of `data_lp_o` and bit k of `data_hs_oe_o`.

Top module: `dphy_mode_seq`

## Requirements
- R1: While reset is held, and while `hs_en_i` is low in the rest state, every lane shows LP11 (`2'b11`). All high-speed enables are 0, `data_valid_o` is 0 and `lead_byte_o` is 0.
- R2: If `hs_en_i` is sampled high in the rest state, the clock lane shows LP01 for exactly one cycle, starting with the next cycle. It then shows LP00 for exactly one cycle. After that `clk_hs_oe_o` rises and `clk_lp_o` stays at LP00.
- R3: After `clk_hs_oe_o` rises, the data lanes hold LP11 for `CLK_LEAD_CYC` cycles. They then show LP01 for one cycle and LP00 for one cycle before `data_hs_oe_o` rises.
- R4: `data_hs_oe_o` is high for `DATA_LEAD_CYC` cycles before `data_valid_o` can rise. During those cycles `lead_byte_o` is 0x00, except in the last cycle, where it is 0xB8.
- R5: `data_valid_o` rises in the cycle after the lead cycles end, provided `hs_en_i` is still high. It stays high until the cycle after `hs_en_i` is sampled low.
- R6: If `hs_en_i` falls before the entry sequence has finished, the entry still runs to its end. `data_valid_o` never rises, and the exit sequence follows at once.
- R7: After `data_valid_o` falls, the data lanes stay in high-speed mode for `DATA_TAIL_CYC` cycles, with `lead_byte_o` at 0.
- R8: The data lanes then return to LP11 with their high-speed enables at 0. The clock lane stays in high-speed mode for `CLK_TAIL_CYC` more cycles and then returns to LP11 with `clk_hs_oe_o` at 0.
- R9: If `hs_en_i` is high during the exit sequence, it has no effect there. At least one cycle in which every lane is at LP11 comes before the next clock-lane LP01.
- R10: All data lanes always show the same LP state and the same high-speed enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_en_i | input | 1 | High-speed request from the packetizer |
| clk_lp_o | output | 2 | Clock lane LP state {p, n} |
| clk_hs_oe_o | output | 1 | Clock lane high-speed driver enable |
| data_lp_o | output | 2*NUM_LANES | Data lane LP states, 2 bits per lane |
| data_hs_oe_o | output | NUM_LANES | Data lane high-speed driver enables |
| data_valid_o | output | 1 | Payload byte strobe toward the serializer |
| lead_byte_o | output | 8 | Byte driven on the data lanes during the lead cycles |

## Verification
The bench sends a request that is shorter than the entry sequence. A design that reacted to the early drop would cut the entry short or raise valid for a stray cycle. It sends a request that outlives the entry by only one cycle, which catches an off-by-one in valid timing or in the lead count. It also raises the next request inside the exit sequence. A design that sampled the request there would skip the LP11 rest cycle, or leave the clock lane before the tail count has elapsed. Each cycle the bench compares every lane's state, the position of the 0xB8 byte and the length of every timed phase against a timeline worked out from the four delays.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_LP01,
    ST_CLK_LP00,
    ST_CLK_HS,
    ST_DAT_LP01,
    ST_DAT_LP00,
    ST_DAT_LEAD,
    ST_ACTIVE,
    ST_DAT_TAIL,
    ST_CLK_TAIL
  } seq_state_e;

  localparam logic [1:0] LP_STOP = 2'b11;
  localparam logic [1:0] LP_REQ  = 2'b01;
  localparam logic [1:0] LP_BRDG = 2'b00;

  localparam logic [7:0] SYNC_BYTE = 8'hB8;

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [WIDTH-1:0] count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (run_i)   count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/seq_lane_map.sv
module seq_lane_map
  import dphy_seq_pkg::*;
#(
  parameter bit IS_CLOCK = 1'b0
) (
  input  seq_state_e state_i,
  output logic [1:0] lp_o,
  output logic       hs_oe_o
);

  generate
    if (IS_CLOCK) begin : g_clock
      always_comb begin
        unique case (state_i)
          ST_IDLE:     begin lp_o = LP_STOP; hs_oe_o = 1'b0; end
          ST_CLK_LP01: begin lp_o = LP_REQ;  hs_oe_o = 1'b0; end
          ST_CLK_LP00: begin lp_o = LP_BRDG; hs_oe_o = 1'b0; end
          default:     begin lp_o = LP_BRDG; hs_oe_o = 1'b1; end
        endcase
      end
    end else begin : g_data
      always_comb begin
        unique case (state_i)
          ST_DAT_LP01: begin lp_o = LP_REQ;  hs_oe_o = 1'b0; end
          ST_DAT_LP00: begin lp_o = LP_BRDG; hs_oe_o = 1'b0; end
          ST_DAT_LEAD,
          ST_ACTIVE,
          ST_DAT_TAIL: begin lp_o = LP_BRDG; hs_oe_o = 1'b1; end
          default:     begin lp_o = LP_STOP; hs_oe_o = 1'b0; end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/dphy_mode_seq.sv
module dphy_mode_seq
  import dphy_seq_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 2,
  parameter int unsigned CLK_LEAD_CYC  = 3,
  parameter int unsigned DATA_LEAD_CYC = 4,
  parameter int unsigned DATA_TAIL_CYC = 2,
  parameter int unsigned CLK_TAIL_CYC  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hs_en_i,
  output logic [1:0]             clk_lp_o,
  output logic                   clk_hs_oe_o,
  output logic [2*NUM_LANES-1:0] data_lp_o,
  output logic [NUM_LANES-1:0]   data_hs_oe_o,
  output logic                   data_valid_o,
  output logic [7:0]             lead_byte_o
);

  localparam int unsigned START_W = $clog2(CLK_LEAD_CYC + DATA_LEAD_CYC + 1);
  localparam int unsigned END_W   = $clog2(DATA_TAIL_CYC + CLK_TAIL_CYC + 1);
  localparam logic [START_W-1:0] CLK_HS_LAST = START_W'(CLK_LEAD_CYC - 1);
  localparam logic [START_W-1:0] LEAD_LAST   = START_W'(CLK_LEAD_CYC + DATA_LEAD_CYC - 1);
  localparam logic [END_W-1:0]   TAIL_LAST   = END_W'(DATA_TAIL_CYC - 1);
  localparam logic [END_W-1:0]   CLK_LAST    = END_W'(DATA_TAIL_CYC + CLK_TAIL_CYC - 1);

  seq_state_e state_q, state_d;
  logic [START_W-1:0] start_cnt;
  logic [END_W-1:0]   end_cnt;
  logic start_run, end_run;

  assign start_run = (state_q == ST_CLK_HS) || (state_q == ST_DAT_LEAD);
  assign end_run   = (state_q == ST_DAT_TAIL) || (state_q == ST_CLK_TAIL);

  // one count spans both entry waits; the LP steps between them hold it
  seq_phase_timer #(.WIDTH(START_W)) i_start_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_IDLE),
    .run_i   (start_run),
    .count_o (start_cnt)
  );

  seq_phase_timer #(.WIDTH(END_W)) i_end_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!end_run),
    .run_i   (end_run),
    .count_o (end_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (hs_en_i) state_d = ST_CLK_LP01;
      ST_CLK_LP01: state_d = ST_CLK_LP00;
      ST_CLK_LP00: state_d = ST_CLK_HS;
      ST_CLK_HS:   if (start_cnt == CLK_HS_LAST) state_d = ST_DAT_LP01;
      ST_DAT_LP01: state_d = ST_DAT_LP00;
      ST_DAT_LP00: state_d = ST_DAT_LEAD;
      ST_DAT_LEAD: if (start_cnt == LEAD_LAST) state_d = hs_en_i ? ST_ACTIVE : ST_DAT_TAIL;
      ST_ACTIVE:   if (!hs_en_i) state_d = ST_DAT_TAIL;
      ST_DAT_TAIL: if (end_cnt == TAIL_LAST) state_d = ST_CLK_TAIL;
      ST_CLK_TAIL: if (end_cnt == CLK_LAST) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  seq_lane_map #(.IS_CLOCK(1'b1)) i_clk_lane (
    .state_i (state_q),
    .lp_o    (clk_lp_o),
    .hs_oe_o (clk_hs_oe_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    seq_lane_map #(.IS_CLOCK(1'b0)) i_data_lane (
      .state_i (state_q),
      .lp_o    (data_lp_o[2*l +: 2]),
      .hs_oe_o (data_hs_oe_o[l])
    );
  end

  assign data_valid_o = (state_q == ST_ACTIVE);
  assign lead_byte_o  = (state_q == ST_DAT_LEAD && start_cnt == LEAD_LAST) ? SYNC_BYTE : 8'h00;

endmodule

module dphy_mode_seq_chk #(
  parameter int unsigned NUM_LANES = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             clk_lp_o,
  input logic                   clk_hs_oe_o,
  input logic [NUM_LANES-1:0]   data_hs_oe_o,
  input logic                   data_valid_o,
  input logic [7:0]             lead_byte_o
);

  // R2
  clk_step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_lp_o == 2'b01) |=> (clk_lp_o == 2'b00 && !clk_hs_oe_o));

  // R2
  clk_hs_in_bridge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_hs_oe_o |-> (clk_lp_o == 2'b00));

  // R3
  data_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hs_oe_o != '0) |-> clk_hs_oe_o);

  // R4
  sync_before_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> ($past(lead_byte_o) == 8'hB8));

  // R5
  valid_needs_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (&data_hs_oe_o));

  // R8
  clk_leaves_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_hs_oe_o) |-> (data_hs_oe_o == '0 && $past(data_hs_oe_o) == '0));

  // R10
  lanes_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hs_oe_o == '0) || (&data_hs_oe_o));

endmodule

bind dphy_mode_seq dphy_mode_seq_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_lp_o     (clk_lp_o),
  .clk_hs_oe_o  (clk_hs_oe_o),
  .data_hs_oe_o (data_hs_oe_o),
  .data_valid_o (data_valid_o),
  .lead_byte_o  (lead_byte_o)
);

// File: tb/test_dphy_mode_seq.sv
module test_dphy_mode_seq;

  localparam int N  = 2;
  localparam int CL = 3;
  localparam int DL = 4;
  localparam int DT = 2;
  localparam int CT = 3;
  localparam int E  = 4 + CL + DL;
  localparam int VW = 2 + 1 + 2*N + N + 1 + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_en = 1'b0;
  logic [1:0]   clk_lp;
  logic         clk_oe;
  logic [2*N-1:0] data_lp;
  logic [N-1:0] data_oe;
  logic         valid;
  logic [7:0]   lead;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dphy_mode_seq #(
    .NUM_LANES(N), .CLK_LEAD_CYC(CL), .DATA_LEAD_CYC(DL),
    .DATA_TAIL_CYC(DT), .CLK_TAIL_CYC(CT)
  ) i_dphy_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .hs_en_i(hs_en),
    .clk_lp_o(clk_lp), .clk_hs_oe_o(clk_oe), .data_lp_o(data_lp),
    .data_hs_oe_o(data_oe), .data_valid_o(valid), .lead_byte_o(lead)
  );

  function automatic logic [VW-1:0] pack(logic [1:0] clp, logic coe, logic [1:0] dlp,
                                         logic doe, logic v, logic [7:0] b);
    return {clp, coe, {N{dlp}}, {N{doe}}, v, b};
  endfunction

  task automatic push(logic [VW-1:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hs_en = 1'b0;
      push(pack(2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00), "R1");
    end
  endtask

  // h: edges hs_en stays high; pre: exit-phase edges with hs_en high; rearm: keep high after
  task automatic burst(int h, int pre, bit rearm);
    int act, len;
    act = (h > E) ? h - E : 0;
    len = E + act + DT + CT;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      hs_en = (k < h) || (k >= len - pre);
      if (k == 0)
        push(pack(2'b01, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00), "R2");
      else if (k == 1)
        push(pack(2'b00, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00), "R2");
      else if (k < 2 + CL)
        push(pack(2'b00, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00), "R3");
      else if (k == 2 + CL)
        push(pack(2'b00, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00), "R3");
      else if (k == 3 + CL)
        push(pack(2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00), "R3");
      else if (k < E)
        push(pack(2'b00, 1'b1, 2'b00, 1'b1, 1'b0, (k == E - 1) ? 8'hB8 : 8'h00), "R4");
      else if (k < E + act)
        push(pack(2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 8'h00), "R5");
      else if (k < E + act + DT)
        push(pack(2'b00, 1'b1, 2'b00, 1'b1, 1'b0, 8'h00),
             (act == 0) ? "R6" : (k >= len - pre) ? "R9" : "R7");
      else
        push(pack(2'b00, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00),
             (act == 0) ? "R6" : (k >= len - pre) ? "R9" : "R8");
    end
    @(negedge clk);
    hs_en = rearm;
    push(pack(2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00), rearm ? "R9" : "R8");
  endtask

  // monitor: pops one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [VW-1:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {clk_lp, clk_oe, data_lp, data_oe, valid, lead};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
      for (int l = 1; l < N; l++) begin
        checks++;
        if (data_lp[2*l +: 2] !== data_lp[1:0] || data_oe[l] !== data_oe[0]) begin
          errors++;
          $display("FAIL R10: lane %0d lp %b oe %b, lane 0 lp %b oe %b",
                   l, data_lp[2*l +: 2], data_oe[l], data_lp[1:0], data_oe[0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({clk_lp, clk_oe, data_lp, data_oe, valid, lead} !==
        pack(2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00)) begin
      errors++;
      $display("FAIL R1: reset outputs %h expected %h",
               {clk_lp, clk_oe, data_lp, data_oe, valid, lead},
               pack(2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 8'h00));
    end
    rst_n = 1'b1;
    idle(4);
    burst(20, 0, 1'b0);
    idle(3);
    burst(3, 0, 1'b0);      // R6: request drops during entry
    idle(2);
    burst(E + 1, 0, 1'b0);  // one valid cycle
    idle(1);
    burst(15, 3, 1'b1);     // R9: request during exit
    burst(14, 0, 1'b0);
    idle(5);
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule